// File: doc/BRIEF.md
# UART-compatible host interrupt logic

This block is the host-facing register slice that lets an embedded modem present itself to a host processor as a 16450-style UART. The host reaches it over an 8-bit parallel bus: three address bits, plus chip select, read strobe and write strobe. The block holds the four-bit interrupt enable register. It derives four interrupt causes from the line status and modem status bits that the modem side supplies. It reports the most urgent pending cause through the identification register and drives one active-high interrupt line to the host.

The strobes are active high and each lasts one clock cycle. Read data is combinational while `cs` and `rd` are both high, and is 0 otherwise. Read side effects and writes take place on the rising clock edge that ends the strobe cycle. Changes in status arrive on `lsr_in` and `msr_in`. Each change is seen at the next clock edge and can be read back in the cycle after that edge.

The divisor-latch access bit comes in from outside the block. It only decides whether address 1 selects the enable register and whether address 0 counts as a transmit-holding write.

Top module: `uart_irq_host`

## Requirements
- R1: With `dlab`=0, a write to address 1 loads bits 3:0 into the enable register, and a read of address 1 returns those bits with bits 7:4 always 0. With `dlab`=1, a write to address 1 leaves the enable register unchanged.
- R2: While enable bit 0 is 1 and `lsr_in[0]` is 1, the received-data cause is pending and the identification register reads 8'h04.
- R3: The transmitter-empty cause (identification value 8'h02) is armed in two cases: when `lsr_in[5]` rises, or when enable bit 1 is written from 0 to 1 while `lsr_in[5]` is 1. It is pending only while `lsr_in[5]` and enable bit 1 are both 1. It clears when the host reads address 2 while the register shows 8'h02, or when the host writes address 0 with `dlab`=0. An arming event in the same cycle wins over a clear.
- R4: With enable bit 2 set, any change of `lsr_in[4:1]` in either direction raises the line-status cause (identification value 8'h06). A read of address 5 clears it. A change that arrives in the same cycle as that read keeps the cause pending.
- R5: With enable bit 3 set, a rise of any bit of `msr_in[3:0]` arms the modem-status cause. Enabling bit 3 while any of those bits is 1 also arms it. The cause is pending while it is armed and any of `msr_in[3:0]` is 1, and the identification register then reads 8'h00. A read of address 6 clears it.
- R6: When several causes are pending, the identification register reports exactly one of them. The order, most urgent first, is line status, received data, transmitter empty, modem status. Bits 2:1 carry the cause code and bits 7:3 are 0.
- R7: When enable bits 3:0 are all 0, the identification register reads 8'h01 and `host_irq` is 0. Reads of address 5 and address 6 still return the live `lsr_in` and `msr_in`.
- R8: `host_irq` is 1 exactly when a cause is pending, which is exactly when bit 0 of the identification register is 0.
- R9: After reset the enable register is 0, the identification register reads 8'h01 and `host_irq` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, one cycle, active high |
| wr | input | 1 | Write strobe, one cycle, active high |
| addr | input | 3 | Register address |
| dlab | input | 1 | Divisor-latch access bit from the line control logic |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, valid while cs and rd are high, otherwise 0 |
| lsr_in | input | 8 | Line status bits from the modem side |
| msr_in | input | 8 | Modem status bits from the modem side |
| host_irq | output | 1 | Interrupt to the host, active high |

## Verification
The host read of address 5 clears the line-status cause. A fresh change on `lsr_in[4:1]` sets that same cause. Both can fall on one clock edge. The bench provokes this by changing `lsr_in[4:1]` on the very cycle it strobes the read. It then judges the outcome by expecting the identification register to read 8'h06 afterwards, and 8'h01 only after a second read with the status held still.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

    localparam int EN_W       = 4;
    localparam int LSR_DR     = 0;
    localparam int LSR_ERR_LO = 1;
    localparam int LSR_ERR_HI = 4;
    localparam int LSR_THRE   = 5;
    localparam int MSR_LO     = 0;
    localparam int MSR_HI     = 3;

    // enable register bit positions
    localparam int EN_RX = 0;
    localparam int EN_TX = 1;
    localparam int EN_LS = 2;
    localparam int EN_MS = 3;

    typedef enum logic [1:0] {
        ID_MS = 2'b00,
        ID_TX = 2'b01,
        ID_RX = 2'b10,
        ID_LS = 2'b11
    } irq_id_e;

    typedef struct packed {
        logic ls;
        logic rx;
        logic tx;
        logic ms;
    } irq_vec_t;

    // low three bits of the identification register
    function automatic logic [2:0] iir_code(input irq_vec_t p);
        if (p.ls) return {ID_LS, 1'b0};
        if (p.rx) return {ID_RX, 1'b0};
        if (p.tx) return {ID_TX, 1'b0};
        if (p.ms) return {ID_MS, 1'b0};
        return 3'b001;
    endfunction

endpackage

// File: rtl/uart_irq_enable.sv
module uart_irq_enable
    import uart_irq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  logic [EN_W-1:0] wr_bits,
    output logic [EN_W-1:0] en,
    output logic [EN_W-1:0] en_rise
);

    logic [EN_W-1:0] en_q;

    always_ff @(posedge clk) begin
        if (rst)        en_q <= '0;
        else if (wr_en) en_q <= wr_bits;
    end

    assign en      = en_q;
    assign en_rise = wr_en ? (wr_bits & ~en_q) : '0;

endmodule

// File: rtl/uart_irq_latch.sv
module uart_irq_latch (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    always_ff @(posedge clk) begin
        if (rst)      flag <= 1'b0;
        else if (set) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

endmodule

// File: rtl/uart_irq_sources.sv
module uart_irq_sources
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] lsr_in,
    input  logic [DATA_W-1:0] msr_in,
    input  logic [EN_W-1:0]   en,
    input  logic [EN_W-1:0]   en_rise,
    input  logic              thr_wr,
    input  logic              iir_rd_tx,
    input  logic              lsr_rd,
    input  logic              msr_rd,
    output irq_vec_t          pend
);

    localparam int N_LATCH = 3;
    localparam int IX_TX   = 0;
    localparam int IX_LS   = 1;
    localparam int IX_MS   = 2;

    logic [DATA_W-1:0]  lsr_q, msr_q;
    logic [N_LATCH-1:0] arm, clr, flag;
    logic               ms_any;

    always_ff @(posedge clk) begin
        if (rst) begin
            lsr_q <= '0;
            msr_q <= '0;
        end else begin
            lsr_q <= lsr_in;
            msr_q <= msr_in;
        end
    end

    assign ms_any = |msr_in[MSR_HI:MSR_LO];

    always_comb begin
        arm[IX_TX] = (lsr_in[LSR_THRE] & ~lsr_q[LSR_THRE])
                   | (en_rise[EN_TX] & lsr_in[LSR_THRE]);
        clr[IX_TX] = thr_wr | iir_rd_tx;

        arm[IX_LS] = en[EN_LS]
                   & (lsr_in[LSR_ERR_HI:LSR_ERR_LO] != lsr_q[LSR_ERR_HI:LSR_ERR_LO]);
        clr[IX_LS] = lsr_rd;

        arm[IX_MS] = (|(msr_in[MSR_HI:MSR_LO] & ~msr_q[MSR_HI:MSR_LO]))
                   | (en_rise[EN_MS] & ms_any);
        clr[IX_MS] = msr_rd;
    end

    for (genvar i = 0; i < N_LATCH; i++) begin : g_latch
        uart_irq_latch u_latch (
            .clk  (clk),
            .rst  (rst),
            .set  (arm[i]),
            .clr  (clr[i]),
            .flag (flag[i])
        );
    end

    always_comb begin
        pend.rx = en[EN_RX] & lsr_in[LSR_DR];
        pend.tx = flag[IX_TX] & en[EN_TX] & lsr_in[LSR_THRE];
        pend.ls = flag[IX_LS] & en[EN_LS];
        pend.ms = flag[IX_MS] & en[EN_MS] & ms_any;
    end

endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  irq_vec_t          pend,
    output logic [DATA_W-1:0] iir,
    output logic              any
);

    always_comb begin
        iir      = '0;
        iir[2:0] = iir_code(pend);
        any      = |pend;
    end

endmodule

// File: rtl/uart_irq_host.sv
module uart_irq_host
    import uart_irq_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3,
    parameter int A_DATA = 0,
    parameter int A_IER  = 1,
    parameter int A_IIR  = 2,
    parameter int A_LSR  = 5,
    parameter int A_MSR  = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs,
    input  logic              rd,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic              dlab,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] lsr_in,
    input  logic [DATA_W-1:0] msr_in,
    output logic              host_irq
);

    localparam logic [ADDR_W-1:0] AD_DATA = ADDR_W'(A_DATA);
    localparam logic [ADDR_W-1:0] AD_IER  = ADDR_W'(A_IER);
    localparam logic [ADDR_W-1:0] AD_IIR  = ADDR_W'(A_IIR);
    localparam logic [ADDR_W-1:0] AD_LSR  = ADDR_W'(A_LSR);
    localparam logic [ADDR_W-1:0] AD_MSR  = ADDR_W'(A_MSR);
    localparam logic [2:0]        TX_CODE = {ID_TX, 1'b0};

    logic              rd_cyc, wr_cyc;
    logic              ier_wr, thr_wr, iir_rd, lsr_rd, msr_rd, iir_rd_tx;
    logic [EN_W-1:0]   ier_q, ier_rise;
    irq_vec_t          pend;
    logic [DATA_W-1:0] iir;
    logic              any;

    assign rd_cyc = cs & rd;
    assign wr_cyc = cs & wr;

    assign ier_wr    = wr_cyc & (addr == AD_IER)  & ~dlab;
    assign thr_wr    = wr_cyc & (addr == AD_DATA) & ~dlab;
    assign iir_rd    = rd_cyc & (addr == AD_IIR);
    assign lsr_rd    = rd_cyc & (addr == AD_LSR);
    assign msr_rd    = rd_cyc & (addr == AD_MSR);
    assign iir_rd_tx = iir_rd & (iir[2:0] == TX_CODE);

    uart_irq_enable u_enable (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (ier_wr),
        .wr_bits (wdata[EN_W-1:0]),
        .en      (ier_q),
        .en_rise (ier_rise)
    );

    uart_irq_sources #(.DATA_W(DATA_W)) u_sources (
        .clk       (clk),
        .rst       (rst),
        .lsr_in    (lsr_in),
        .msr_in    (msr_in),
        .en        (ier_q),
        .en_rise   (ier_rise),
        .thr_wr    (thr_wr),
        .iir_rd_tx (iir_rd_tx),
        .lsr_rd    (lsr_rd),
        .msr_rd    (msr_rd),
        .pend      (pend)
    );

    uart_irq_prio #(.DATA_W(DATA_W)) u_prio (
        .pend (pend),
        .iir  (iir),
        .any  (any)
    );

    assign host_irq = any;

    always_comb begin
        rdata = '0;
        if (rd_cyc) begin
            unique case (addr)
                AD_IER:  if (!dlab) rdata[EN_W-1:0] = ier_q;
                AD_IIR:  rdata = iir;
                AD_LSR:  rdata = lsr_in;
                AD_MSR:  rdata = msr_in;
                default: rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/uart_irq_host_chk.sv
module uart_irq_host_chk #(
    parameter int DATA_W = 8,
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              cs,
    input logic              rd,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic              dlab,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] lsr_in,
    input logic              host_irq,
    input logic [3:0]        ier
);

    // R1: upper enable bits read as zero
    p_ier_hi_zero_r1: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && addr == ADDR_W'(1) && !dlab) |-> (rdata[DATA_W-1:4] == '0));

    // R2: received data with its enable raises the interrupt
    p_rx_irq_r2: assert property (@(posedge clk) disable iff (rst)
        (ier[0] && lsr_in[0]) |-> host_irq);

    // R3: a transmit-holding write clears a lone transmitter cause
    p_thr_clear_r3: assert property (@(posedge clk) disable iff (rst)
        (cs && wr && addr == ADDR_W'(0) && !dlab && ier == 4'b0010
         && lsr_in[5] && $past(lsr_in[5])) |=> !host_irq);

    // R7: all enables clear keeps the line low
    p_quiet_r7: assert property (@(posedge clk) disable iff (rst)
        (ier == 4'b0000) |-> !host_irq);

    // R7: line status reads stay live
    p_lsr_live_r7: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && addr == ADDR_W'(5)) |-> (rdata == lsr_in));

    // R8: interrupt line agrees with identification bit 0
    p_irq_iir_r8: assert property (@(posedge clk) disable iff (rst)
        (cs && rd && addr == ADDR_W'(2)) |-> (host_irq == !rdata[0]));

    // R9: reset clears enables and the line
    p_reset_r9: assert property (@(posedge clk)
        rst |=> (!host_irq && ier == 4'b0000));

endmodule

bind uart_irq_host uart_irq_host_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .cs       (cs),
    .rd       (rd),
    .wr       (wr),
    .addr     (addr),
    .dlab     (dlab),
    .rdata    (rdata),
    .lsr_in   (lsr_in),
    .host_irq (host_irq),
    .ier      (ier_q)
);

// File: tb/uart_irq_host_bench.sv
module uart_irq_host_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0, dlab = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] lsr_in = '0;
    logic [7:0] msr_in = '0;
    logic       host_irq;

    int  checks = 0;
    int  errors = 0;
    bit  done = 1'b0;

    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #2 clk = ~clk;

    uart_irq_host u_uart_irq_host (
        .clk      (clk),
        .rst      (rst),
        .cs       (cs),
        .rd       (rd),
        .wr       (wr),
        .addr     (addr),
        .dlab     (dlab),
        .wdata    (wdata),
        .rdata    (rdata),
        .lsr_in   (lsr_in),
        .msr_in   (msr_in),
        .host_irq (host_irq)
    );

    // monitor: pops expected read data and compares
    initial begin : monitor
        logic [7:0] e;
        string      t;
        forever begin
            @(negedge clk);
            #1;
            if (cs && rd) begin
                checks++;
                if (exp_q.size() == 0) begin
                    errors++;
                    $display("FAIL read without expectation actual=%02h expected=none", rdata);
                end else begin
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    if (rdata !== e) begin
                        errors++;
                        $display("FAIL %s actual=%02h expected=%02h", t, rdata, e);
                    end
                end
            end
        end
    end

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d, input logic dl);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d; dlab = dl;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0; dlab = 1'b0;
    endtask

    // read, optionally changing status in the same cycle
    task automatic bus_read_st(input logic [2:0] a, input logic [7:0] e, input string t,
                               input bit chg, input logic [7:0] l);
        @(negedge clk);
        exp_q.push_back(e);
        tag_q.push_back(t);
        if (chg) lsr_in = l;
        cs = 1'b1; rd = 1'b1; addr = a; dlab = 1'b0;
        @(negedge clk);
        cs = 1'b0; rd = 1'b0;
    endtask

    task automatic bus_read(input logic [2:0] a, input logic [7:0] e, input string t);
        bus_read_st(a, e, t, 1'b0, 8'h00);
    endtask

    task automatic set_status(input logic [7:0] l, input logic [7:0] m);
        @(negedge clk);
        lsr_in = l;
        msr_in = m;
    endtask

    task automatic chk_irq(input logic e, input string t);
        @(negedge clk);
        #1;
        checks++;
        if (host_irq !== e) begin
            errors++;
            $display("FAIL %s host_irq actual=%0b expected=%0b", t, host_irq, e);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : driver
        repeat (4) @(negedge clk);
        rst = 1'b0;

        // R9: reset state
        chk_irq(1'b0, "R9 reset irq");
        bus_read(3'd2, 8'h01, "R9 reset iir");
        bus_read(3'd1, 8'h00, "R9 reset ier");

        // R1: enable register access
        bus_write(3'd1, 8'hFF, 1'b0);
        bus_read(3'd1, 8'h0F, "R1 upper bits zero");
        bus_read(3'd2, 8'h01, "R1 nothing pending");
        bus_write(3'd1, 8'h00, 1'b0);
        bus_write(3'd1, 8'h05, 1'b1);
        bus_read(3'd1, 8'h00, "R1 dlab write ignored");

        // R7: disabled, status still live
        set_status(8'h3F, 8'h0F);
        chk_irq(1'b0, "R7 disabled irq");
        bus_read(3'd2, 8'h01, "R7 disabled iir");
        bus_read(3'd5, 8'h3F, "R7 lsr live");
        bus_read(3'd6, 8'h0F, "R7 msr live");
        set_status(8'h00, 8'h00);

        // R2: received data
        bus_write(3'd1, 8'h01, 1'b0);
        set_status(8'h01, 8'h00);
        chk_irq(1'b1, "R2 R8 rx irq");
        bus_read(3'd2, 8'h04, "R2 rx iir");
        set_status(8'h00, 8'h00);
        chk_irq(1'b0, "R2 rx gone");
        bus_read(3'd2, 8'h01, "R2 rx gone iir");

        // R3: transmitter empty
        bus_write(3'd1, 8'h02, 1'b0);
        set_status(8'h20, 8'h00);
        chk_irq(1'b1, "R3 tx irq");
        bus_read(3'd2, 8'h02, "R3 tx iir");
        bus_read(3'd2, 8'h01, "R3 cleared by iir read");
        chk_irq(1'b0, "R3 irq after iir read");
        bus_write(3'd1, 8'h00, 1'b0);
        bus_write(3'd1, 8'h02, 1'b0);
        chk_irq(1'b1, "R3 rearm on enable");
        bus_write(3'd0, 8'h55, 1'b0);
        chk_irq(1'b0, "R3 cleared by thr write");
        bus_read(3'd2, 8'h01, "R3 thr clear iir");
        set_status(8'h00, 8'h00);
        set_status(8'h20, 8'h00);
        bus_read(3'd2, 8'h02, "R3 rearm on rise");
        set_status(8'h00, 8'h00);

        // R4: line status
        bus_write(3'd1, 8'h04, 1'b0);
        set_status(8'h02, 8'h00);
        chk_irq(1'b1, "R4 ls irq");
        bus_read(3'd2, 8'h06, "R4 ls iir");
        bus_read(3'd5, 8'h02, "R4 lsr read");
        bus_read(3'd2, 8'h01, "R4 cleared by lsr read");
        set_status(8'h00, 8'h00);
        bus_read(3'd2, 8'h06, "R4 falling change");
        bus_read_st(3'd5, 8'h10, "R4 read with change", 1'b1, 8'h10);
        bus_read(3'd2, 8'h06, "R4 change wins over clear");
        bus_read(3'd5, 8'h10, "R4 second lsr read");
        bus_read(3'd2, 8'h01, "R4 cleared after stable read");

        // R5: modem status
        bus_write(3'd1, 8'h08, 1'b0);
        set_status(8'h10, 8'h04);
        chk_irq(1'b1, "R5 ms irq");
        bus_read(3'd2, 8'h00, "R5 ms iir");
        bus_read(3'd6, 8'h04, "R5 msr read");
        bus_read(3'd2, 8'h01, "R5 cleared by msr read");
        chk_irq(1'b0, "R5 irq after msr read");
        set_status(8'h10, 8'h0C);
        bus_read(3'd2, 8'h00, "R5 new rise");
        bus_read(3'd6, 8'h0C, "R5 msr read again");
        set_status(8'h10, 8'h00);
        bus_read(3'd2, 8'h01, "R5 idle");

        // R6: priority
        bus_write(3'd1, 8'h0F, 1'b0);
        set_status(8'h21, 8'h01);
        chk_irq(1'b1, "R6 R8 all pending");
        bus_read(3'd2, 8'h06, "R6 ls first");
        bus_read(3'd5, 8'h21, "R6 lsr read");
        bus_read(3'd2, 8'h04, "R6 rx second");
        set_status(8'h20, 8'h01);
        bus_read(3'd2, 8'h02, "R6 tx third");
        bus_read(3'd2, 8'h00, "R6 ms fourth");
        bus_read(3'd6, 8'h01, "R6 msr read");
        bus_read(3'd2, 8'h01, "R6 none left");
        chk_irq(1'b0, "R6 R8 irq low");

        // R7: disabling masks a pending level cause
        set_status(8'h21, 8'h00);
        chk_irq(1'b1, "R7 rx before disable");
        bus_write(3'd1, 8'h00, 1'b0);
        chk_irq(1'b0, "R7 masked irq");
        bus_read(3'd2, 8'h01, "R7 masked iir");

        @(negedge clk);
        checks++;
        if (exp_q.size() != 0) begin
            errors++;
            $display("FAIL R8 pending reads actual=%0d expected=0", exp_q.size());
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule